// File: doc/BRIEF.md
# Row Repair Address Remapper

This block sits on the row-address path of a four-array embedded DRAM macro. Every array is built from eight micro-arrays, and every micro-array carries 32 normal rows plus a single spare row on the same local bit-line. After reset, a shared table of 16 repair entries is shifted in one entry per cycle from the fuse latches. Each entry names one failing row by array, micro-array and row. Row lookups stay blocked until all 16 entries have been loaded.

Once the table is loaded, each valid access is compared against all entries at once. On a match, the access goes to the spare row of the same micro-array, and the normal row select is held at zero. Any one micro-array can be repaired only once, so an array takes at most eight repairs. The shared table is smaller than four times eight, which limits repairs for the macro as a whole. When two valid entries aim at the same micro-array, a configuration-error flag is raised, and only the entry with the lower index takes effect.

Top module: `rr_remap`

## Requirements
- R1: When reset is asserted, every output goes to 0: word-line valid, array, micro-array, row, spare select, repair hit, load done and configuration error.
- R2: Each cycle in which fuse_vld is high, fuse_data is stored into the next table slot, in order from slot 0 to slot 15. The fields of fuse_data are: bit 10 valid, bits 9:8 array, bits 7:5 micro-array, bits 4:0 row. load_done goes high at the clock edge that stores the 16th entry and is low before that edge.
- R3: Before load_done is high, an access produces no word-line valid and no repair hit.
- R4: After loading, an access with no matching entry presented at a clock edge gives, at that edge, wl_vld=1, the same array, micro-array and row, wl_spare=0 and repair_hit=0.
- R5: After loading, an access that matches an effective entry gives, at that edge, repair_hit=1 and wl_spare=1, with wl_row forced to 0 so that the normal word-line is suppressed.
- R6: A repaired access keeps the array and micro-array of the access, so the spare row used is always the one inside the addressed micro-array.
- R7: An entry whose valid bit is 0 never causes a hit.
- R8: Loading a valid entry whose array and micro-array equal those of an earlier valid entry sets cfg_err at that load edge. cfg_err then stays high until reset. Only the earlier, lower-numbered entry repairs that micro-array.
- R9: fuse_vld pulses after load_done is high do not change the repair table.
- R10: A cycle with acc_vld low gives wl_vld=0 and repair_hit=0 at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fuse_vld | input | 1 | Fuse entry strobe |
| fuse_data | input | 11 | Fuse entry {valid, array, micro-array, row} |
| acc_vld | input | 1 | Access valid |
| acc_array | input | 2 | Access array index |
| acc_micro | input | 3 | Access micro-array index |
| acc_row | input | 5 | Access row within micro-array |
| load_done | output | 1 | Repair table fully loaded |
| cfg_err | output | 1 | Duplicate micro-array repair seen (sticky) |
| wl_vld | output | 1 | Word-line select valid |
| wl_array | output | 2 | Selected array |
| wl_micro | output | 3 | Selected micro-array |
| wl_row | output | 5 | Selected normal row (0 when spare used) |
| wl_spare | output | 1 | Spare row of the selected micro-array selected |
| repair_hit | output | 1 | Access was redirected to a spare |

## Verification
A fuse entry is written into the table at the clock edge that samples it. load_done and cfg_err reflect that entry right after the same edge. Every word-line result is registered once, so it appears at the edge that samples the access. The bench changes inputs on the falling clock edge and reads outputs on the following falling edge, which falls exactly one register stage after the stimulus. The lookup is swept over all 1024 array, micro-array and row combinations, for a table that contains duplicates and for a table that does not. The expected hit for each address is worked out from the lowest-numbered valid entry that targets that micro-array.

// File: rtl/rr_pkg.sv
package rr_pkg;
   localparam int RR_DEF_ARRAYS  = 4;
   localparam int RR_DEF_MICROS  = 8;
   localparam int RR_DEF_ROWS    = 32;
   localparam int RR_DEF_ENTRIES = 16;

   function automatic int rr_bits(input int n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/rr_fuse_table.sv
module rr_fuse_table #(
   parameter int N  = 16,
   parameter int AW = 2,
   parameter int MW = 3,
   parameter int RW = 5,
   localparam int EW    = 1 + AW + MW + RW,
   localparam int CNT_W = $clog2(N + 1),
   localparam int IDX_W = (N <= 1) ? 1 : $clog2(N)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fuse_vld,
   input  logic [EW-1:0]        fuse_data,
   output logic                 load_done,
   output logic                 cfg_err,
   output logic [N-1:0]         tbl_eff,
   output logic [N-1:0][AW-1:0] tbl_arr,
   output logic [N-1:0][MW-1:0] tbl_mic,
   output logic [N-1:0][RW-1:0] tbl_row
);
   logic [CNT_W-1:0] cnt;
   logic [N-1:0]     tbl_vld;
   logic             in_vld;
   logic [AW-1:0]    in_arr;
   logic [MW-1:0]    in_mic;
   logic [RW-1:0]    in_row;
   logic             conflict;
   logic             take;
   logic [IDX_W-1:0] slot;

   assign in_vld    = fuse_data[EW-1];
   assign in_arr    = fuse_data[RW+MW +: AW];
   assign in_mic    = fuse_data[RW +: MW];
   assign in_row    = fuse_data[RW-1:0];
   assign load_done = (cnt == CNT_W'(N));
   assign take      = fuse_vld && !load_done;
   assign slot      = cnt[IDX_W-1:0];

   always_comb begin
      conflict = 1'b0;
      for (int j = 0; j < N; j++) begin
         if ((CNT_W'(j) < cnt) && tbl_vld[j] &&
             (tbl_arr[j] == in_arr) && (tbl_mic[j] == in_mic))
            conflict = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         cfg_err <= 1'b0;
         tbl_vld <= '0;
         tbl_eff <= '0;
         tbl_arr <= '0;
         tbl_mic <= '0;
         tbl_row <= '0;
      end else if (take) begin
         cnt           <= cnt + 1'b1;
         tbl_vld[slot] <= in_vld;
         tbl_eff[slot] <= in_vld && !conflict;
         tbl_arr[slot] <= in_arr;
         tbl_mic[slot] <= in_mic;
         tbl_row[slot] <= in_row;
         if (in_vld && conflict) cfg_err <= 1'b1;
      end
   end

   // R2
   load_done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |=> load_done);
   // R8
   cfg_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err);
   // R9
   table_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |=> ($stable(tbl_eff) && $stable(tbl_row) && $stable(tbl_arr) && $stable(tbl_mic)));
endmodule

// File: rtl/rr_match.sv
module rr_match #(
   parameter int N  = 16,
   parameter int AW = 2,
   parameter int MW = 3,
   parameter int RW = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [AW-1:0]        acc_array,
   input  logic [MW-1:0]        acc_micro,
   input  logic [RW-1:0]        acc_row,
   input  logic [N-1:0]         tbl_eff,
   input  logic [N-1:0][AW-1:0] tbl_arr,
   input  logic [N-1:0][MW-1:0] tbl_mic,
   input  logic [N-1:0][RW-1:0] tbl_row,
   output logic                 hit
);
   logic [N-1:0] match_vec;

   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign match_vec[i] = tbl_eff[i] && (tbl_arr[i] == acc_array) &&
                            (tbl_mic[i] == acc_micro) && (tbl_row[i] == acc_row);
   end

   assign hit = |match_vec;

   // R8
   single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_vec));
endmodule

// File: rtl/rr_wl_out.sv
module rr_wl_out #(
   parameter int AW = 2,
   parameter int MW = 3,
   parameter int RW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          acc_vld,
   input  logic          load_done,
   input  logic          hit,
   input  logic [AW-1:0] acc_array,
   input  logic [MW-1:0] acc_micro,
   input  logic [RW-1:0] acc_row,
   output logic          wl_vld,
   output logic [AW-1:0] wl_array,
   output logic [MW-1:0] wl_micro,
   output logic [RW-1:0] wl_row,
   output logic          wl_spare,
   output logic          repair_hit
);
   logic go;
   assign go = acc_vld && load_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wl_vld     <= 1'b0;
         wl_array   <= '0;
         wl_micro   <= '0;
         wl_row     <= '0;
         wl_spare   <= 1'b0;
         repair_hit <= 1'b0;
      end else begin
         wl_vld     <= go;
         wl_array   <= go ? acc_array : '0;
         wl_micro   <= go ? acc_micro : '0;
         wl_row     <= (go && !hit) ? acc_row : '0;
         wl_spare   <= go && hit;
         repair_hit <= go && hit;
      end
   end

   // R3
   blocked_until_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wl_vld |-> $past(load_done));
   // R10
   idle_no_wl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_vld |=> (!wl_vld && !repair_hit));
   // R5
   spare_suppresses_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      repair_hit |-> (wl_spare && wl_vld && (wl_row == '0)));
   // R6
   same_micro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_vld && load_done) |=> ((wl_array == $past(acc_array)) && (wl_micro == $past(acc_micro))));
endmodule

// File: rtl/rr_remap.sv
module rr_remap #(
   parameter int NUM_ARRAYS  = rr_pkg::RR_DEF_ARRAYS,
   parameter int NUM_MICROS  = rr_pkg::RR_DEF_MICROS,
   parameter int NUM_ROWS    = rr_pkg::RR_DEF_ROWS,
   parameter int NUM_ENTRIES = rr_pkg::RR_DEF_ENTRIES,
   localparam int AW = rr_pkg::rr_bits(NUM_ARRAYS),
   localparam int MW = rr_pkg::rr_bits(NUM_MICROS),
   localparam int RW = rr_pkg::rr_bits(NUM_ROWS),
   localparam int EW = 1 + AW + MW + RW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fuse_vld,
   input  logic [EW-1:0] fuse_data,
   input  logic          acc_vld,
   input  logic [AW-1:0] acc_array,
   input  logic [MW-1:0] acc_micro,
   input  logic [RW-1:0] acc_row,
   output logic          load_done,
   output logic          cfg_err,
   output logic          wl_vld,
   output logic [AW-1:0] wl_array,
   output logic [MW-1:0] wl_micro,
   output logic [RW-1:0] wl_row,
   output logic          wl_spare,
   output logic          repair_hit
);
   initial begin
      assert (NUM_ARRAYS == (1 << AW)) else $error("NUM_ARRAYS must be a power of two");
      assert (NUM_MICROS == (1 << MW)) else $error("NUM_MICROS must be a power of two");
      assert (NUM_ROWS == (1 << RW))   else $error("NUM_ROWS must be a power of two");
      assert (NUM_ENTRIES >= 1 && NUM_ENTRIES <= NUM_ARRAYS * NUM_MICROS)
         else $error("NUM_ENTRIES out of range");
   end

   logic [NUM_ENTRIES-1:0]         tbl_eff;
   logic [NUM_ENTRIES-1:0][AW-1:0] tbl_arr;
   logic [NUM_ENTRIES-1:0][MW-1:0] tbl_mic;
   logic [NUM_ENTRIES-1:0][RW-1:0] tbl_row;
   logic                           hit;

   rr_fuse_table #(.N(NUM_ENTRIES), .AW(AW), .MW(MW), .RW(RW)) u_table (
      .clk(clk), .rst_n(rst_n), .fuse_vld(fuse_vld), .fuse_data(fuse_data),
      .load_done(load_done), .cfg_err(cfg_err), .tbl_eff(tbl_eff),
      .tbl_arr(tbl_arr), .tbl_mic(tbl_mic), .tbl_row(tbl_row)
   );

   rr_match #(.N(NUM_ENTRIES), .AW(AW), .MW(MW), .RW(RW)) u_match (
      .clk(clk), .rst_n(rst_n), .acc_array(acc_array), .acc_micro(acc_micro),
      .acc_row(acc_row), .tbl_eff(tbl_eff), .tbl_arr(tbl_arr),
      .tbl_mic(tbl_mic), .tbl_row(tbl_row), .hit(hit)
   );

   rr_wl_out #(.AW(AW), .MW(MW), .RW(RW)) u_out (
      .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .load_done(load_done),
      .hit(hit), .acc_array(acc_array), .acc_micro(acc_micro), .acc_row(acc_row),
      .wl_vld(wl_vld), .wl_array(wl_array), .wl_micro(wl_micro),
      .wl_row(wl_row), .wl_spare(wl_spare), .repair_hit(repair_hit)
   );

   // R4
   miss_passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wl_vld && !repair_hit) |-> !wl_spare);
endmodule

// File: tb/rr_remap_tb.sv
module rr_remap_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fuse_vld = 1'b0;
   logic [10:0] fuse_data = '0;
   logic        acc_vld = 1'b0;
   logic [1:0]  acc_array = '0;
   logic [2:0]  acc_micro = '0;
   logic [4:0]  acc_row = '0;
   logic        load_done, cfg_err, wl_vld, wl_spare, repair_hit;
   logic [1:0]  wl_array;
   logic [2:0]  wl_micro;
   logic [4:0]  wl_row;

   int checks = 0;
   int failures = 0;
   logic        t_vld [16];
   logic [1:0]  t_arr [16];
   logic [2:0]  t_mic [16];
   logic [4:0]  t_row [16];

   always #(CLK_PERIOD/2) clk = ~clk;

   rr_remap u_dut (
      .clk(clk), .rst_n(rst_n), .fuse_vld(fuse_vld), .fuse_data(fuse_data),
      .acc_vld(acc_vld), .acc_array(acc_array), .acc_micro(acc_micro), .acc_row(acc_row),
      .load_done(load_done), .cfg_err(cfg_err), .wl_vld(wl_vld), .wl_array(wl_array),
      .wl_micro(wl_micro), .wl_row(wl_row), .wl_spare(wl_spare), .repair_hit(repair_hit)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int outs();
      return {wl_vld, wl_array, wl_micro, wl_row, wl_spare, repair_hit};
   endfunction

   // lowest-numbered valid entry aimed at a micro-array decides its repair
   function automatic bit exp_hit(input int a, input int m, input int r);
      for (int i = 0; i < 16; i++)
         if (t_vld[i] && t_arr[i] == 2'(a) && t_mic[i] == 3'(m))
            return (t_row[i] == 5'(r));
      return 1'b0;
   endfunction

   task automatic load_one(input int i);
      @(negedge clk);
      fuse_vld  = 1'b1;
      fuse_data = {t_vld[i], t_arr[i], t_mic[i], t_row[i]};
      @(negedge clk);
      fuse_vld  = 1'b0;
   endtask

   task automatic access(input int a, input int m, input int r);
      acc_vld = 1'b1; acc_array = 2'(a); acc_micro = 3'(m); acc_row = 5'(r);
      @(negedge clk);
      acc_vld = 1'b0;
   endtask

   task automatic sweep(input string req);
      for (int a = 0; a < 4; a++)
         for (int m = 0; m < 8; m++)
            for (int r = 0; r < 32; r++) begin
               bit h;
               h = exp_hit(a, m, r);
               access(a, m, r);
               check(req, outs(), {1'b1, 2'(a), 3'(m), h ? 5'd0 : 5'(r), h, h});
            end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      // table A: entry i+8 repeats the micro-array of entry i; entry 5 invalid
      for (int i = 0; i < 16; i++) begin
         t_vld[i] = (i != 5);
         t_arr[i] = 2'(i % 4);
         t_mic[i] = 3'((3 * i) % 8);
         t_row[i] = 5'((7 * i + 3) % 32);
      end
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", {outs(), load_done, cfg_err}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R3 access before any load is blocked
      access(t_arr[0], t_mic[0], t_row[0]);
      check("R3", {wl_vld, repair_hit}, 0);
      for (int i = 0; i < 8; i++) load_one(i);
      check("R8 no duplicate yet", cfg_err, 0);
      access(t_arr[0], t_mic[0], t_row[0]);
      check("R3 partial load", {wl_vld, repair_hit}, 0);
      load_one(8);
      check("R8 duplicate flagged", cfg_err, 1);
      for (int i = 9; i < 15; i++) load_one(i);
      check("R2 not done after 15", load_done, 0);
      load_one(15);
      check("R2 done after 16", load_done, 1);
      // R4 R5 R6 R7 R8 full address sweep
      sweep("R4/R5/R6/R7/R8 table A");
      // R8 shadowed entry 8 does not hit
      access(t_arr[8], t_mic[8], t_row[8]);
      check("R8 shadowed entry", repair_hit, 0);
      // R7 invalid entry 5 does not hit
      access(t_arr[5], t_mic[5], t_row[5]);
      check("R7 invalid entry", repair_hit, 0);
      // R10 idle cycle
      @(negedge clk);
      check("R10 idle", {wl_vld, repair_hit}, 0);
      // R9 late fuse strobe targets an unrepaired address
      @(negedge clk);
      fuse_vld = 1'b1; fuse_data = {1'b1, 2'd1, 3'd1, 5'd9};
      @(negedge clk);
      fuse_vld = 1'b0;
      access(1, 1, 9);
      check("R9 late load ignored", {repair_hit, wl_row}, {1'b0, 5'd9});
      check("R8 sticky", cfg_err, 1);
      // table B: no duplicates; entry 2 invalid
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset clears", {outs(), load_done, cfg_err}, 0);
      rst_n = 1'b1;
      for (int i = 0; i < 16; i++) begin
         t_vld[i] = (i != 2);
         t_arr[i] = 2'(i % 4);
         t_mic[i] = 3'(i / 4);
         t_row[i] = 5'((5 * i + 1) % 32);
      end
      for (int i = 0; i < 16; i++) load_one(i);
      check("R2 done", load_done, 1);
      check("R8 no duplicates", cfg_err, 0);
      sweep("R4/R5/R6/R7 table B");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule